// File: doc/BRIEF.md
# Decimal Correction Unit

This unit repairs the result of binary arithmetic so that it reads again as decimal digits. It works on an 8-bit accumulator byte and the 8-bit byte above it, and it takes the carry and half-carry flags from the arithmetic step before. It returns the corrected pair, new carry and half-carry flags, and zero, sign and parity flags taken from the corrected low byte. A 3-bit operation code selects the correction. Two codes handle one decimal digit per byte after an add or a subtract. Two codes handle one digit per byte around a multiply or a divide. Two codes handle two digits packed in one byte after an add or a subtract.

Requests enter through a valid/ready handshake. An accepted request produces its result in a single output register one clock later. A request can be accepted on every cycle, so the unit runs at full rate when the consumer does not stall. When the consumer stalls, the held result stays unchanged and the unit refuses new work.

Top module: `dec_adjust_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and its result appears with `out_valid`=1 after that edge. `in_ready` is 1 whenever the output register is empty or `out_ready` is 1. While `out_valid`=1 and `out_ready`=0, all outputs hold their values and no new request is taken.
- R3: Op code 0 (unpacked add). If the low nibble of AL is greater than 9 or AF=1, then AL becomes AL+6, AH becomes AH+1, and CF and AF are set. Otherwise CF and AF are cleared. In both cases the upper nibble of the resulting AL is forced to 0. Example: AH=00h, AL=0Fh gives AH=01h, AL=05h.
- R4: Op code 1 (unpacked subtract). This uses the same condition as R3, but with AL−6 and AH−1. The upper nibble of AL is cleared and CF and AF follow the condition. Example: AH=02h, AL=FFh gives AH=01h, AL=09h.
- R5: Op code 2 (after multiply). AH becomes AL/10, AL becomes AL mod 10, and CF and AF are cleared. Example: AL=0Fh gives AH=01h, AL=05h.
- R6: Op code 3 (before divide). AL becomes (AH×10+AL) mod 256, AH becomes 0, and CF and AF are cleared. Example: AH=01h, AL=05h gives AL=0Fh.
- R7: Op code 4 (packed add). If the low nibble is greater than 9 or AF=1, 06h is added and AF is set; otherwise AF is cleared. Then, if the original AL was greater than 99h or CF=1, 60h is added and CF is set; otherwise CF is cleared. AH passes through unchanged. Example: AL=0Fh gives 15h.
- R8: Op code 5 (packed subtract). This follows R7 with 06h and 60h subtracted instead of added, and AH passes through unchanged. Example: AL=FFh gives 99h with CF=1.
- R9: Op codes 6 and 7 return AL, AH, CF and AF unchanged.
- R10: ZF is 1 when the result AL is 00h. SF equals bit 7 of the result AL. PF is 1 when the result AL has an even number of 1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Correction select (R3–R9) |
| in_al | input | 8 | Accumulator low byte |
| in_ah | input | 8 | Accumulator high byte |
| in_cf | input | 1 | Incoming carry flag |
| in_af | input | 1 | Incoming half-carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_al | output | 8 | Corrected low byte |
| out_ah | output | 8 | Corrected high byte |
| out_cf | output | 1 | Resulting carry flag |
| out_af | output | 1 | Resulting half-carry flag |
| out_zf | output | 1 | Result low byte is zero |
| out_sf | output | 1 | Bit 7 of result low byte |
| out_pf | output | 1 | Even parity of result low byte |

## Verification
The only state is the output register, so a wrong value caught there shows on the ports one cycle after the request that produced it. A lost or duplicated handshake shows at once as `out_valid` or `in_ready` in the wrong state. A bad value held through a stall stays visible until the consumer takes it. The sweep covers every AL value with every flag combination for all eight codes and several AH values. This exposes a wrong nibble threshold, a wrong 99h boundary, or a swapped sign of correction on the first cycle the result is shown.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NIB_W     = 4;
    localparam int unsigned OP_W      = 3;
    localparam logic [NIB_W-1:0]  NIB_MAX_DIGIT = 4'd9;
    localparam logic [BYTE_W-1:0] LOW_FIX       = 8'h06;
    localparam logic [BYTE_W-1:0] HIGH_FIX      = 8'h60;
    localparam logic [BYTE_W-1:0] PACKED_MAX    = 8'h99;
    localparam logic [BYTE_W-1:0] TEN           = 8'd10;

    typedef enum logic [OP_W-1:0] {
        OP_UNP_ADD = 3'd0,
        OP_UNP_SUB = 3'd1,
        OP_UNP_MUL = 3'd2,
        OP_UNP_DIV = 3'd3,
        OP_PCK_ADD = 3'd4,
        OP_PCK_SUB = 3'd5,
        OP_PASS_A  = 3'd6,
        OP_PASS_B  = 3'd7
    } adj_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] al;
        logic [BYTE_W-1:0] ah;
        logic              cf;
        logic              af;
    } adj_res_t;

    typedef struct packed {
        logic              valid;
        adj_res_t          res;
        logic              zf;
        logic              sf;
        logic              pf;
    } out_reg_t;

endpackage

// File: rtl/dadj_unpacked.sv
module dadj_unpacked
    import dadj_pkg::*;
(
    input  logic              sub,
    input  logic [BYTE_W-1:0] al,
    input  logic [BYTE_W-1:0] ah,
    input  logic              af,
    output adj_res_t          res
);
    logic              need_fix;
    logic [BYTE_W-1:0] al_fix;
    logic [BYTE_W-1:0] ah_fix;
    logic [BYTE_W-1:0] al_sel;

    always_comb begin
        need_fix = (al[NIB_W-1:0] > NIB_MAX_DIGIT) || af;
        al_fix   = sub ? (al - LOW_FIX) : (al + LOW_FIX);
        ah_fix   = sub ? (ah - 8'd1) : (ah + 8'd1);
        al_sel   = need_fix ? al_fix : al;
        res.al   = {{(BYTE_W-NIB_W){1'b0}}, al_sel[NIB_W-1:0]};
        res.ah   = need_fix ? ah_fix : ah;
        res.cf   = need_fix;
        res.af   = need_fix;
    end
endmodule

// File: rtl/dadj_muldiv.sv
module dadj_muldiv
    import dadj_pkg::*;
(
    input  logic              is_div,
    input  logic [BYTE_W-1:0] al,
    input  logic [BYTE_W-1:0] ah,
    output adj_res_t          res
);
    logic [BYTE_W-1:0] quot;
    logic [BYTE_W-1:0] rem;
    logic [BYTE_W-1:0] ah_x10;

    always_comb begin
        quot   = al / TEN;
        rem    = al % TEN;
        ah_x10 = ah * TEN;
        if (is_div) begin
            res.al = ah_x10 + al;
            res.ah = '0;
        end else begin
            res.al = rem;
            res.ah = quot;
        end
        res.cf = 1'b0;
        res.af = 1'b0;
    end
endmodule

// File: rtl/dadj_packed.sv
module dadj_packed
    import dadj_pkg::*;
(
    input  logic              sub,
    input  logic [BYTE_W-1:0] al,
    input  logic [BYTE_W-1:0] ah,
    input  logic              cf,
    input  logic              af,
    output adj_res_t          res
);
    logic              low_fix;
    logic              high_fix;
    logic [BYTE_W-1:0] step1;
    logic [BYTE_W-1:0] step2;

    always_comb begin
        low_fix  = (al[NIB_W-1:0] > NIB_MAX_DIGIT) || af;
        high_fix = (al > PACKED_MAX) || cf;
        step1    = al;
        if (low_fix)
            step1 = sub ? (al - LOW_FIX) : (al + LOW_FIX);
        step2    = step1;
        if (high_fix)
            step2 = sub ? (step1 - HIGH_FIX) : (step1 + HIGH_FIX);
        res.al   = step2;
        res.ah   = ah;
        res.cf   = high_fix;
        res.af   = low_fix;
    end
endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
    import dadj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [BYTE_W-1:0] in_al,
    input  logic [BYTE_W-1:0] in_ah,
    input  logic              in_cf,
    input  logic              in_af,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_al,
    output logic [BYTE_W-1:0] out_ah,
    output logic              out_cf,
    output logic              out_af,
    output logic              out_zf,
    output logic              out_sf,
    output logic              out_pf
);
    adj_op_e  op;
    adj_res_t unp_res;
    adj_res_t md_res;
    adj_res_t pck_res;
    adj_res_t pass_res;
    adj_res_t sel_res;
    out_reg_t st_d;
    out_reg_t st_q;
    logic     accept;

    assign op = adj_op_e'(in_op);

    dadj_unpacked u_unp (
        .sub (in_op[0]),
        .al  (in_al),
        .ah  (in_ah),
        .af  (in_af),
        .res (unp_res)
    );

    dadj_muldiv u_md (
        .is_div (in_op[0]),
        .al     (in_al),
        .ah     (in_ah),
        .res    (md_res)
    );

    dadj_packed u_pck (
        .sub (in_op[0]),
        .al  (in_al),
        .ah  (in_ah),
        .cf  (in_cf),
        .af  (in_af),
        .res (pck_res)
    );

    always_comb begin
        pass_res.al = in_al;
        pass_res.ah = in_ah;
        pass_res.cf = in_cf;
        pass_res.af = in_af;
        unique case (op)
            OP_UNP_ADD, OP_UNP_SUB: sel_res = unp_res;
            OP_UNP_MUL, OP_UNP_DIV: sel_res = md_res;
            OP_PCK_ADD, OP_PCK_SUB: sel_res = pck_res;
            default:                sel_res = pass_res;
        endcase
    end

    always_comb begin
        in_ready = !st_q.valid || out_ready;
        accept   = in_valid && in_ready;
        st_d     = st_q;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.res   = sel_res;
            st_d.zf    = (sel_res.al == '0);
            st_d.sf    = sel_res.al[BYTE_W-1];
            st_d.pf    = ~^sel_res.al;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_al    = st_q.res.al;
    assign out_ah    = st_q.res.ah;
    assign out_cf    = st_q.res.cf;
    assign out_af    = st_q.res.af;
    assign out_zf    = st_q.zf;
    assign out_sf    = st_q.sf;
    assign out_pf    = st_q.pf;
endmodule

// File: rtl/dec_adjust_chk.sv
module dec_adjust_chk
    import dadj_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [OP_W-1:0]   in_op,
    input logic [BYTE_W-1:0] in_al,
    input logic [BYTE_W-1:0] in_ah,
    input logic              in_cf,
    input logic              in_af,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_al,
    input logic [BYTE_W-1:0] out_ah,
    input logic              out_cf,
    input logic              out_af,
    input logic              out_zf,
    input logic              out_sf,
    input logic              out_pf
);
    logic acc;
    assign acc = in_valid && in_ready;

    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_al) && $stable(out_ah)
                                       && $stable(out_cf) && $stable(out_af))); // R2
    AST_UADD_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 3'd0) |=> (out_al[7:4] == 4'd0)); // R3
    AST_USUB_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 3'd1) |=> (out_al[7:4] == 4'd0 && out_cf == out_af)); // R4
    AST_MUL_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 3'd2) |=> (out_al < 8'd10 && out_ah < 8'd26 && !out_cf)); // R5
    AST_DIV_AH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 3'd3) |=> (out_ah == 8'd0 && !out_cf && !out_af)); // R6
    AST_PACKED_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 3'd4 && in_al > 8'h99) |=> out_cf); // R7
    AST_PACKED_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == 3'd5 && in_cf) |=> out_cf); // R8
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op[2:1] == 2'b11) |=> (out_al == $past(in_al) && out_ah == $past(in_ah)
                                          && out_cf == $past(in_cf) && out_af == $past(in_af))); // R9
    AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sf == out_al[7] && (!out_zf || out_al == 8'd0))); // R10
endmodule

bind dec_adjust_unit dec_adjust_chk u_chk (.*);

// File: tb/dec_adjust_unit_tb.sv
module dec_adjust_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_op = '0;
    logic [7:0] in_al = '0;
    logic [7:0] in_ah = '0;
    logic       in_cf = 1'b0;
    logic       in_af = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_al, out_ah;
    logic       out_cf, out_af, out_zf, out_sf, out_pf;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dec_adjust_unit u_dut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic string req_of(int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Expected {al, ah, cf, af, zf, sf, pf} from the requirement text.
    function automatic logic [20:0] model(int op, int al, int ah, int cf, int af);
        int ral, rah, rcf, raf, ones;
        ral = al; rah = ah; rcf = cf; raf = af;
        case (op)
            0, 1: begin
                if ((al % 16) > 9 || af == 1) begin
                    ral = (op == 0) ? al + 6 : al - 6;
                    rah = (op == 0) ? ah + 1 : ah - 1;
                    rcf = 1; raf = 1;
                end else begin
                    rcf = 0; raf = 0;
                end
                ral = ((ral % 256 + 256) % 256) % 16;
                rah = (rah + 256) % 256;
            end
            2: begin ral = al % 10; rah = al / 10; rcf = 0; raf = 0; end
            3: begin ral = (ah * 10 + al) % 256; rah = 0; rcf = 0; raf = 0; end
            4, 5: begin
                raf = ((al % 16) > 9 || af == 1) ? 1 : 0;
                rcf = (al > 153 || cf == 1) ? 1 : 0;
                ral = al + ((op == 4) ? 1 : -1) * (6 * raf + 96 * rcf);
                ral = (ral % 256 + 256) % 256;
            end
            default: ;
        endcase
        ones = 0;
        for (int b = 0; b < 8; b++) ones += (ral >> b) & 1;
        return {ral[7:0], rah[7:0], rcf[0], raf[0], ral == 0, ral[7], (ones % 2) == 0};
    endfunction

    task automatic check(string req, string what, logic [20:0] act, logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic one_op(int op, int al, int ah, int cf, int af);
        @(negedge clk);
        in_valid = 1'b1; in_op = op[2:0]; in_al = al[7:0]; in_ah = ah[7:0];
        in_cf = cf[0]; in_af = af[0];
        @(negedge clk);
        in_valid = 1'b0;
        check(req_of(op), "result", {out_al, out_ah, out_cf, out_af, out_zf, out_sf, out_pf},
              model(op, al, ah, cf, af));
        check("R10", "valid", {20'd0, out_valid}, 21'd1);
    endtask

    initial begin
        int ahs[4] = '{8'h00, 8'h02, 8'h37, 8'hFF};
        repeat (3) @(negedge clk);
        check("R1", "valid after reset", {20'd0, out_valid}, 21'd0);
        check("R1", "ready after reset", {20'd0, in_ready}, 21'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after release", {19'd0, out_valid, in_ready}, 21'd1);

        // Worked examples
        one_op(0, 8'h0F, 8'h00, 0, 0);
        check("R3", "example", {out_ah, out_al, 5'd0}, {8'h01, 8'h05, 5'd0});
        one_op(1, 8'hFF, 8'h02, 0, 0);
        check("R4", "example", {out_ah, out_al, 5'd0}, {8'h01, 8'h09, 5'd0});
        one_op(2, 8'h0F, 8'h00, 0, 0);
        check("R5", "example", {out_ah, out_al, 5'd0}, {8'h01, 8'h05, 5'd0});
        one_op(3, 8'h05, 8'h01, 0, 0);
        check("R6", "example", {out_ah, out_al, 5'd0}, {8'h00, 8'h0F, 5'd0});
        one_op(4, 8'h0F, 8'h00, 0, 0);
        check("R7", "example", {13'd0, out_al}, {13'd0, 8'h15});
        one_op(5, 8'hFF, 8'h00, 0, 0);
        check("R8", "example", {12'd0, out_al, out_cf}, {12'd0, 8'h99, 1'b1});

        // Exhaustive sweep over op, AL, CF, AF with several AH values
        for (int op = 0; op < 8; op++)
            for (int k = 0; k < 4; k++)
                for (int fl = 0; fl < 4; fl++)
                    for (int al = 0; al < 256; al++)
                        one_op(op, al, ahs[k], fl & 1, fl >> 1);

        // Back-to-back at full rate (R2)
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'd2; in_al = 8'd99; in_ah = 8'd0; in_cf = 0; in_af = 0;
        @(negedge clk);
        check("R2", "stream first", {out_ah, out_al, 4'd0, out_valid}, {8'd9, 8'd9, 4'd0, 1'b1});
        in_op = 3'd3; in_al = 8'd7; in_ah = 8'd4;
        @(negedge clk);
        check("R2", "stream second", {out_ah, out_al, 4'd0, out_valid}, {8'd0, 8'd47, 4'd0, 1'b1});
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", "drain", {20'd0, out_valid}, 21'd0);

        // Stall behaviour (R2)
        out_ready = 1'b0;
        in_valid = 1'b1; in_op = 3'd2; in_al = 8'h2A; in_ah = 8'h00;
        @(negedge clk);
        check("R2", "stall ready low", {19'd0, out_valid, in_ready}, {19'd0, 1'b1, 1'b0});
        in_op = 3'd3; in_al = 8'h05; in_ah = 8'h07;
        @(negedge clk);
        check("R2", "stall hold", {out_ah, out_al, 4'd0, out_valid}, {8'h04, 8'h02, 4'd0, 1'b1});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "after stall", {out_ah, out_al, 4'd0, out_valid}, {8'h00, 8'h4B, 4'd0, 1'b1});
        @(negedge clk);
        check("R2", "empty", {19'd0, out_valid, in_ready}, {19'd0, 1'b0, 1'b1});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule